// File: doc/BRIEF.md
# Host-to-PCI Write Posting Controller

This block sits between a CPU write request port and the request port of a PCI master engine. It decides, write by write, whether the CPU may go on at once or must wait for the PCI bus. It captures each accepted write in a single-entry buffer and hands the PCI engine one 4-byte transfer at a time. When a transfer is retried on PCI, the block either reissues it by itself or reports the retry back to the CPU.

Memory-space writes are posted: the CPU gets its acknowledge as soon as the data sits in the buffer. I/O-space writes wait for PCI completion. A write that enables bytes in both 4-byte halves of its 8-byte lane is split into two transfers. The CPU waits on the lower half. The upper half is then posted. An inbound PCI master access to system memory, seen when such a split write arrives, makes the CPU try again later.

Top module: `posted_write_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, pciReq, cpuAck and cpuRetry are low.
- R2: A memory write with bytes in one half only is acknowledged once, one cycle after acceptance, before its PCI transfer completes. The PCI transfer carries address bits [31:3] from the CPU, bit 2 set for the upper half (cpuBe[7:4], cpuData[63:32]) and clear for the lower half (cpuBe[3:0], cpuData[31:0]), and bits [1:0] zero. pciIo is low.
- R3: When a posted transfer gets pciRetry, the block requests it again with the same address, enables and data until pciDone arrives. The CPU sees no retry.
- R4: An I/O write (cpuIo high) is acknowledged only after its PCI transfer completes. If the transfer gets pciRetry, the CPU gets cpuRetry and the transfer is not issued again.
- R5: A write with bytes enabled in both halves produces two PCI transfers, lower half first. The CPU is acknowledged once the lower one completes, and the upper one is then carried out as a posted transfer.
- R6: If the lower transfer of a split write is retried on PCI, the CPU gets cpuRetry and the upper transfer is never issued.
- R7: If inboundHit is high in the cycle a split write is presented in the idle state, the CPU gets cpuRetry and no PCI transfer is issued.
- R8: If the upper transfer of a split write is retried on PCI, it is reissued until done, with no further CPU response. This holds for I/O split writes too.
- R9: While a posted transfer is outstanding, a new CPU write is not accepted. Its acknowledge comes only after the outstanding transfer completes, and the transfers reach PCI in CPU order.
- R10: cpuAck and cpuRetry are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU write request, held until cpuAck or cpuRetry |
| cpuAddr | input | 32 | CPU byte address; bits [2:0] are ignored |
| cpuBe | input | 8 | Byte enables for the 8-byte lane, nonzero |
| cpuData | input | 64 | Write data, byte i on bits [8i+7:8i] |
| cpuIo | input | 1 | 1 for I/O space, 0 for memory space |
| inboundHit | input | 1 | An inbound PCI master access to system memory is pending |
| cpuAck | output | 1 | One-cycle pulse: the CPU write is finished |
| cpuRetry | output | 1 | One-cycle pulse: the CPU must repeat the write |
| pciReq | output | 1 | Request for a 4-byte PCI write |
| pciAddr | output | 32 | PCI address, 4-byte aligned |
| pciBe | output | 4 | PCI byte enables |
| pciData | output | 32 | PCI write data |
| pciIo | output | 1 | Space of the PCI transfer |
| pciDone | input | 1 | One-cycle pulse: the transfer completed |
| pciRetry | input | 1 | One-cycle pulse: the transfer was retried |

## Verification
The assertions assume the CPU holds its request fields steady from request to response and drops the request in the cycle it sees a response. They also assume cpuBe is never zero. On the PCI side they assume pciDone and pciRetry arrive only while pciReq is high, never together, and for one cycle each. The bench meets these assumptions in two ways. Its CPU task changes inputs only at falling edges and releases the request as soon as a response shows. Its PCI engine model answers a request only after a fixed latency and clears its answer on the next falling edge.

// File: rtl/wpost_pkg.sv
package wpost_pkg;
  typedef enum logic [1:0] {
    WP_IDLE,
    WP_HOLD,
    WP_POST
  } wpState_t;

  typedef struct packed {
    logic load;
    logic nextHalf;
  } wpStrobe_t;
endpackage

// File: rtl/wpost_datapath.sv
module wpost_datapath
  import wpost_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wpStrobe_t             strb,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [2*HALF_W/8-1:0] cpuBe,
  input  logic [2*HALF_W-1:0]   cpuData,
  input  logic                  cpuIo,
  output logic                  reqDouble,
  output logic [ADDR_W-1:0]     pciAddr,
  output logic [HALF_W/8-1:0]   pciBe,
  output logic [HALF_W-1:0]     pciData,
  output logic                  pciIo
);
  localparam int HB  = HALF_W / 8;
  localparam int OFS = $clog2(HB);

  logic [ADDR_W-1:OFS+1] addrQ;
  logic [2*HB-1:0]       beQ;
  logic [2*HALF_W-1:0]   dataQ;
  logic                  ioQ;
  logic                  halfQ;

  logic loHas, hiHas;
  assign loHas     = |cpuBe[HB-1:0];
  assign hiHas     = |cpuBe[2*HB-1:HB];
  assign reqDouble = loHas && hiHas;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= '0;
      dataQ <= '0;
      ioQ   <= 1'b0;
      halfQ <= 1'b0;
    end else if (strb.load) begin
      addrQ <= cpuAddr[ADDR_W-1:OFS+1];
      beQ   <= cpuBe;
      dataQ <= cpuData;
      ioQ   <= cpuIo;
      halfQ <= !loHas;
    end else if (strb.nextHalf) begin
      halfQ <= 1'b1;
    end
  end

  assign pciAddr = {addrQ, halfQ, {OFS{1'b0}}};
  assign pciBe   = halfQ ? beQ[2*HB-1:HB] : beQ[HB-1:0];
  assign pciData = halfQ ? dataQ[2*HALF_W-1:HALF_W] : dataQ[HALF_W-1:0];
  assign pciIo   = ioQ;

  // R5: stepping to the upper half always lands on the upper address
  assert_upper_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.nextHalf |=> pciAddr[OFS]);
  // R2: a fresh load keeps the upper address bits of the CPU request
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> pciAddr[ADDR_W-1:OFS+1] == $past(cpuAddr[ADDR_W-1:OFS+1]));
endmodule

// File: rtl/wpost_ctrl.sv
module wpost_ctrl
  import wpost_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuIo,
  input  logic      reqDouble,
  input  logic      inboundHit,
  input  logic      pciDone,
  input  logic      pciRetry,
  output wpStrobe_t strb,
  output logic      pciReq,
  output logic      cpuAck,
  output logic      cpuRetry
);
  wpState_t state, nxt;
  logic     dblQ;
  logic     ackD, retD;

  always_comb begin
    strb = '0;
    nxt  = state;
    ackD = 1'b0;
    retD = 1'b0;
    unique case (state)
      WP_IDLE: if (cpuReq) begin
        if (reqDouble && inboundHit) begin
          retD = 1'b1;
        end else begin
          strb.load = 1'b1;
          if (!cpuIo && !reqDouble) begin
            ackD = 1'b1;
            nxt  = WP_POST;
          end else begin
            nxt = WP_HOLD;
          end
        end
      end
      WP_HOLD: if (pciRetry) begin
        retD = 1'b1;
        nxt  = WP_IDLE;
      end else if (pciDone) begin
        ackD = 1'b1;
        if (dblQ) begin
          strb.nextHalf = 1'b1;
          nxt           = WP_POST;
        end else begin
          nxt = WP_IDLE;
        end
      end
      WP_POST: if (pciDone) nxt = WP_IDLE;
      default: nxt = WP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= WP_IDLE;
      dblQ     <= 1'b0;
      cpuAck   <= 1'b0;
      cpuRetry <= 1'b0;
    end else begin
      state    <= nxt;
      cpuAck   <= ackD;
      cpuRetry <= retD;
      if (strb.load) dblQ <= reqDouble;
    end
  end

  assign pciReq = (state != WP_IDLE);

  assert_ack_retry_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuAck && cpuRetry));
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);
  assert_retry_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuRetry |=> !cpuRetry);
  assert_hold_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == WP_HOLD && !pciDone && !pciRetry) |=> !cpuAck && !cpuRetry);
  assert_post_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == WP_POST && pciRetry) |=> pciReq && !cpuRetry && !cpuAck);
  assert_inbound_retry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == WP_IDLE && cpuReq && reqDouble && inboundHit) |=> cpuRetry && !pciReq);
endmodule

// File: rtl/posted_write_ctrl.sv
module posted_write_ctrl
  import wpost_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuReq,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [2*HALF_W/8-1:0] cpuBe,
  input  logic [2*HALF_W-1:0]   cpuData,
  input  logic                  cpuIo,
  input  logic                  inboundHit,
  output logic                  cpuAck,
  output logic                  cpuRetry,
  output logic                  pciReq,
  output logic [ADDR_W-1:0]     pciAddr,
  output logic [HALF_W/8-1:0]   pciBe,
  output logic [HALF_W-1:0]     pciData,
  output logic                  pciIo,
  input  logic                  pciDone,
  input  logic                  pciRetry
);
  wpStrobe_t strb;
  logic      reqDouble;

  wpost_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuIo(cpuIo),
    .reqDouble(reqDouble), .inboundHit(inboundHit),
    .pciDone(pciDone), .pciRetry(pciRetry), .strb(strb),
    .pciReq(pciReq), .cpuAck(cpuAck), .cpuRetry(cpuRetry)
  );

  wpost_datapath #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .cpuBe(cpuBe), .cpuData(cpuData), .cpuIo(cpuIo),
    .reqDouble(reqDouble), .pciAddr(pciAddr), .pciBe(pciBe),
    .pciData(pciData), .pciIo(pciIo)
  );

  // R3: an unanswered transfer stays requested and unchanged
  assert_xfer_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pciReq && !pciDone && !pciRetry) |=>
      pciReq && $stable(pciAddr) && $stable(pciBe) && $stable(pciData));
  // R2: a requested transfer always enables at least one byte
  assert_be_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    pciReq |-> (pciBe != '0));
endmodule

// File: tb/posted_write_ctrl_bench.sv
module posted_write_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [7:0]  cpuBe = '0;
  logic [63:0] cpuData = '0;
  logic        cpuIo = 1'b0;
  logic        inboundHit = 1'b0;
  logic        cpuAck, cpuRetry, pciReq, pciIo;
  logic [31:0] pciAddr, pciData;
  logic [3:0]  pciBe;
  logic        pciDone = 1'b0;
  logic        pciRetry = 1'b0;

  always #5 clk = ~clk;

  posted_write_ctrl u_posted_write_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .cpuBe(cpuBe), .cpuData(cpuData), .cpuIo(cpuIo), .inboundHit(inboundHit),
    .cpuAck(cpuAck), .cpuRetry(cpuRetry), .pciReq(pciReq), .pciAddr(pciAddr),
    .pciBe(pciBe), .pciData(pciData), .pciIo(pciIo),
    .pciDone(pciDone), .pciRetry(pciRetry)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // PCI engine model: answers each attempt after lat cycles of request
  logic [31:0] logAddr [0:15];
  logic [3:0]  logBe   [0:15];
  logic [31:0] logData [0:15];
  logic        logIo   [0:15];
  bit          retryPlan [0:15];
  int nAtt = 0;
  int lat = 3;
  int waitCnt = 0;

  always @(negedge clk) begin
    if (pciDone || pciRetry) begin
      pciDone  = 1'b0;
      pciRetry = 1'b0;
      waitCnt  = 0;
    end else if (pciReq && rstN) begin
      waitCnt++;
      if (waitCnt >= lat) begin
        if (nAtt < 16) begin
          logAddr[nAtt] = pciAddr;
          logBe[nAtt]   = pciBe;
          logData[nAtt] = pciData;
          logIo[nAtt]   = pciIo;
          pciRetry = retryPlan[nAtt];
          pciDone  = !retryPlan[nAtt];
        end else begin
          pciDone = 1'b1;
        end
        nAtt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  // response monitor for R10
  int bothCnt = 0;
  int longCnt = 0;
  int retryEvents = 0;
  logic prevAck = 1'b0;
  logic prevRetry = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (cpuAck && cpuRetry) bothCnt++;
      if ((cpuAck && prevAck) || (cpuRetry && prevRetry)) longCnt++;
      if (cpuRetry) retryEvents++;
      prevAck   = cpuAck;
      prevRetry = cpuRetry;
    end
  end

  task automatic clearLog();
    for (int i = 0; i < 16; i++) retryPlan[i] = 1'b0;
    nAtt = 0;
  endtask

  task automatic quiet();
    repeat (40) @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [31:0] a, input logic [7:0] be,
                          input logic [63:0] d, input logic io, input logic hit,
                          output logic acked, output int attAtResp);
    int guard;
    @(negedge clk);
    cpuReq = 1'b1; cpuAddr = a; cpuBe = be; cpuData = d; cpuIo = io; inboundHit = hit;
    guard = 0;
    acked = 1'b0;
    attAtResp = -1;
    while (guard < 500) begin
      @(negedge clk);
      guard++;
      if (cpuAck || cpuRetry) begin
        acked = cpuAck;
        attAtResp = nAtt;
        break;
      end
    end
    cpuReq = 1'b0; inboundHit = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 pciReq in reset", {63'b0, pciReq}, 64'd0);
    chk("R1 cpuAck in reset", {63'b0, cpuAck}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {61'b0, pciReq, cpuAck, cpuRetry}, 64'd0);
  endtask

  task automatic testMemSingle();
    logic ok; int att;
    clearLog();
    cpuWrite(32'h1000_000B, 8'h03, 64'h5566_7788_AABB_CCDD, 1'b0, 1'b0, ok, att);
    chk("R2 lower acked", {63'b0, ok}, 64'd1);
    chk("R2 ack before completion", att, 0);
    quiet();
    chk("R2 lower one transfer", nAtt, 1);
    chk("R2 lower addr", logAddr[0], 32'h1000_0008);
    chk("R2 lower be", logBe[0], 4'h3);
    chk("R2 lower data", logData[0], 32'hAABB_CCDD);
    chk("R2 lower space", logIo[0], 1'b0);
    clearLog();
    cpuWrite(32'h2000_0000, 8'hC0, 64'h1122_3344_0000_0000, 1'b0, 1'b0, ok, att);
    chk("R2 upper acked early", att, 0);
    quiet();
    chk("R2 upper addr", logAddr[0], 32'h2000_0004);
    chk("R2 upper be", logBe[0], 4'hC);
    chk("R2 upper data", logData[0], 32'h1122_3344);
  endtask

  task automatic testPostedRetry();
    logic ok; int att; int r0;
    clearLog();
    retryPlan[0] = 1'b1; retryPlan[1] = 1'b1;
    r0 = retryEvents;
    cpuWrite(32'h4000_0100, 8'h0F, 64'h0000_0000_DEAD_BEEF, 1'b0, 1'b0, ok, att);
    chk("R3 acked", {63'b0, ok}, 64'd1);
    quiet();
    chk("R3 attempts", nAtt, 3);
    chk("R3 reissue addr", logAddr[2], 32'h4000_0100);
    chk("R3 reissue data", logData[2], 32'hDEAD_BEEF);
    chk("R3 no cpu retry", retryEvents - r0, 0);
  endtask

  task automatic testIo();
    logic ok; int att;
    clearLog();
    cpuWrite(32'h8000_0020, 8'h01, 64'h0000_0000_0000_005A, 1'b1, 1'b0, ok, att);
    chk("R4 io acked", {63'b0, ok}, 64'd1);
    chk("R4 ack after completion", att, 1);
    quiet();
    chk("R4 io space", logIo[0], 1'b1);
    clearLog();
    retryPlan[0] = 1'b1;
    cpuWrite(32'h8000_0024, 8'h02, 64'h0000_0000_0000_6600, 1'b1, 1'b0, ok, att);
    chk("R4 io retried to cpu", {63'b0, ok}, 64'd0);
    chk("R4 retry after attempt", att, 1);
    quiet();
    chk("R4 no reissue", nAtt, 1);
  endtask

  task automatic testDouble();
    logic ok; int att;
    clearLog();
    cpuWrite(32'h3000_0010, 8'hFF, 64'h8877_6655_4433_2211, 1'b0, 1'b0, ok, att);
    chk("R5 acked", {63'b0, ok}, 64'd1);
    chk("R5 ack after lower", att, 1);
    quiet();
    chk("R5 two transfers", nAtt, 2);
    chk("R5 lower addr", logAddr[0], 32'h3000_0010);
    chk("R5 lower data", logData[0], 32'h4433_2211);
    chk("R5 upper addr", logAddr[1], 32'h3000_0014);
    chk("R5 upper data", logData[1], 32'h8877_6655);
    chk("R5 upper be", logBe[1], 4'hF);
  endtask

  task automatic testDoubleFirstRetry();
    logic ok; int att;
    clearLog();
    retryPlan[0] = 1'b1;
    cpuWrite(32'h3000_0040, 8'h3C, 64'h0, 1'b0, 1'b0, ok, att);
    chk("R6 cpu retried", {63'b0, ok}, 64'd0);
    quiet();
    chk("R6 no upper transfer", nAtt, 1);
  endtask

  task automatic testInbound();
    logic ok; int att;
    clearLog();
    cpuWrite(32'h3000_0080, 8'hFF, 64'h0, 1'b0, 1'b1, ok, att);
    chk("R7 cpu retried", {63'b0, ok}, 64'd0);
    quiet();
    chk("R7 no transfer", nAtt, 0);
  endtask

  task automatic testDoubleSecondRetry();
    logic ok; int att; int r0;
    clearLog();
    retryPlan[1] = 1'b1;
    r0 = retryEvents;
    cpuWrite(32'h9000_0008, 8'hF1, 64'hCAFE_0000_0000_0077, 1'b1, 1'b0, ok, att);
    chk("R8 acked", {63'b0, ok}, 64'd1);
    quiet();
    chk("R8 attempts", nAtt, 3);
    chk("R8 reissued upper addr", logAddr[2], 32'h9000_000C);
    chk("R8 reissued upper data", logData[2], 32'hCAFE_0000);
    chk("R8 upper io", logIo[2], 1'b1);
    chk("R8 no cpu retry", retryEvents - r0, 0);
  endtask

  task automatic testStall();
    logic ok; int att;
    clearLog();
    lat = 6;
    cpuWrite(32'h5000_0000, 8'h0F, 64'h0000_0000_AAAA_0001, 1'b0, 1'b0, ok, att);
    chk("R9 first early ack", att, 0);
    cpuWrite(32'h5000_0100, 8'h0F, 64'h0000_0000_BBBB_0002, 1'b0, 1'b0, ok, att);
    chk("R9 second ack waits", att, 1);
    quiet();
    chk("R9 order first", logAddr[0], 32'h5000_0000);
    chk("R9 order second", logAddr[1], 32'h5000_0100);
    lat = 3;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) retryPlan[i] = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    testMemSingle();
    testPostedRetry();
    testIo();
    testDouble();
    testDoubleFirstRetry();
    testInbound();
    testDoubleSecondRetry();
    testStall();
    chk("R10 ack and retry together", bothCnt, 0);
    chk("R10 response longer than one cycle", longCnt, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule